// File: doc/BRIEF.md
# Search Triplet Step Engine

This block carries out a single branch step of the bus identifier search on a single-wire bus. After a start request it asks an external slot generator for two read slots. The first returns the identifier bit that every responding device drives, and the second returns its complement. From the two values it decides which branch of the identifier tree to follow. It then asks the slot generator for one write slot carrying that direction, which deselects the devices on the other branch.

The decision has three cases. When the two values disagree, the direction is the identifier bit. When both read 0, devices sit on both branches and the direction comes from a preferred-direction input that the caller supplies with the start. When both read 1, no device answered, and the step ends at once without a write slot. The caller gets a 3-bit status word with a one-cycle done pulse.

A higher-level search controller sits above this block and owns the 64-step walk, the discrepancy tracking and the CRC check. A slot generator sits below it and owns the bus timing. Each slot is requested with a one-cycle pulse and is complete when the slot generator returns a one-cycle done pulse.

Top module: `rom_search_step`

## Requirements
- R1: While reset is low, and on the first cycle after it, `busy_o`, `slot_req_o` and `done_o` are 0 and `status_o` is 3'b000.
- R2: A `start_i` sampled high while idle makes `slot_req_o` high on the next cycle with `slot_wr_o`=0 (a read slot), and `busy_o` high from that cycle on.
- R3: The cycle after the first read slot's `slot_done_i`, a second read slot is requested. The value on `slot_bit_i` with the first done is the identifier bit and goes to status bit 0. The value with the second done is the complement bit and goes to status bit 1.
- R4: If both reads return 1, no write slot is requested and the status is 3'b011.
- R5: If both reads return 0, the write slot carries the preferred direction sampled with the accepted start, on `slot_val_o`. The status is 3'b100 for direction 1 and 3'b000 for direction 0.
- R6: If exactly one read returns 1, the write slot carries the identifier bit. The status is 3'b101 when the identifier bit is 1 and 3'b010 when the complement bit is 1.
- R7: The cycle after the second read completes is a decision cycle with no request and no done. On abort, `done_o` rises on the cycle after the decision cycle. Otherwise `done_o` rises on the cycle after the write slot's `slot_done_i`. `done_o` lasts exactly one cycle, and `busy_o` is 0 on the cycle after it.
- R8: A `start_i` or a change of `pref_dir_i` while busy has no effect on the step in progress and starts no second step.
- R9: `status_o` changes only on the cycle in which `done_o` is high and holds its value otherwise.
- R10: `slot_req_o` is a one-cycle pulse, issued once per slot. A `slot_done_i` that arrives with no slot outstanding, including while idle, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin one search step (accepted only when idle) |
| pref_dir_i | input | 1 | Direction to take when both reads return 0 |
| slot_req_o | output | 1 | One-cycle request for a bus slot |
| slot_wr_o | output | 1 | Slot kind for the request: 0 read, 1 write |
| slot_val_o | output | 1 | Bit to write in a write slot |
| slot_done_i | input | 1 | One-cycle pulse from the slot generator: requested slot finished |
| slot_bit_i | input | 1 | Bus level sampled during a read slot, valid with `slot_done_i` |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle pulse: step finished, `status_o` updated |
| status_o | output | 3 | {direction taken, complement bit, identifier bit} |

## Verification
A wrong sequencer state shows at the slot interface within one cycle. Symptoms include a missing or doubled `slot_req_o` pulse, a read where a write was due, or a write slot after two 1 reads. A wrongly captured identifier or complement bit first shows on `slot_val_o` during the write request. At the latest it shows in `status_o` on the done cycle of the same step. A stale preferred direction appears only when both reads return 0, so the stimulus drives that case together with start pulses issued while busy.

// File: rtl/srch_trip_pkg.sv
// Shared types for the search triplet step engine.
// Assumes: none; holds only type definitions.
package srch_trip_pkg;

    // Sequencer states; one slot is outstanding in each *_WAIT state.
    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_ID_REQ   = 4'd1,
        ST_ID_WAIT  = 4'd2,
        ST_CMP_REQ  = 4'd3,
        ST_CMP_WAIT = 4'd4,
        ST_DECIDE   = 4'd5,
        ST_DIR_REQ  = 4'd6,
        ST_DIR_WAIT = 4'd7,
        ST_REPORT   = 4'd8
    } step_state_t;

    // Status word; the last member is bit 0.
    typedef struct packed {
        logic dir_taken;
        logic cmp_bit;
        logic id_bit;
    } step_result_t;

endpackage

// File: rtl/srch_trip_branch.sv
// Branch decision for one search step.
// Combinational: from the captured identifier bit, complement bit and
// preferred direction it derives the abort flag, the direction to write
// and the status word.
// Assumes its inputs are stable while the sequencer uses its outputs.
module srch_trip_branch
    import srch_trip_pkg::*;
(
    input  logic         id_bit_i,
    input  logic         cmp_bit_i,
    input  logic         pref_dir_i,
    output logic         abort_o,
    output logic         dir_o,
    output step_result_t result_o
);

    // Pick the branch: a lone 1 wins, two 0s defer to the caller, two 1s abort.
    always_comb begin
        abort_o = id_bit_i & cmp_bit_i;
        if (id_bit_i ^ cmp_bit_i)
            dir_o = id_bit_i;
        else if (!id_bit_i && !cmp_bit_i)
            dir_o = pref_dir_i;
        else
            dir_o = 1'b0;
        result_o.id_bit    = id_bit_i;
        result_o.cmp_bit   = cmp_bit_i;
        result_o.dir_taken = dir_o;
    end

endmodule

// File: rtl/srch_trip_seq.sv
// Slot sequencer for one search step.
// It requests read, read and write slots in turn, captures the two read
// values and the preferred direction, and signals when the result must be
// published.
// Assumes: the slot generator answers each one-cycle request with one
// one-cycle done pulse no earlier than the cycle after the request.
module srch_trip_seq
    import srch_trip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic pref_dir_i,
    input  logic slot_done_i,
    input  logic slot_bit_i,
    input  logic abort_i,
    output logic slot_req_o,
    output logic slot_wr_o,
    output logic busy_o,
    output logic done_o,
    output logic publish_o,
    output logic id_q_o,
    output logic cmp_q_o,
    output logic pref_q_o
);

    step_state_t state, state_nx;

    // Next-state selection; starts are honoured only in idle.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (start_i) state_nx = ST_ID_REQ;
            ST_ID_REQ:   state_nx = ST_ID_WAIT;
            ST_ID_WAIT:  if (slot_done_i) state_nx = ST_CMP_REQ;
            ST_CMP_REQ:  state_nx = ST_CMP_WAIT;
            ST_CMP_WAIT: if (slot_done_i) state_nx = ST_DECIDE;
            ST_DECIDE:   state_nx = abort_i ? ST_REPORT : ST_DIR_REQ;
            ST_DIR_REQ:  state_nx = ST_DIR_WAIT;
            ST_DIR_WAIT: if (slot_done_i) state_nx = ST_REPORT;
            ST_REPORT:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the caller's preferred direction with an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pref_q_o <= 1'b0;
        else if (state == ST_IDLE && start_i) pref_q_o <= pref_dir_i;
    end

    // Capture the identifier and complement bits as their read slots finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q_o  <= 1'b0;
            cmp_q_o <= 1'b0;
        end else if (slot_done_i) begin
            if (state == ST_ID_WAIT)  id_q_o  <= slot_bit_i;
            if (state == ST_CMP_WAIT) cmp_q_o <= slot_bit_i;
        end
    end

    // Decode slot requests and handshake flags from the state.
    always_comb begin
        slot_req_o = (state == ST_ID_REQ) || (state == ST_CMP_REQ) || (state == ST_DIR_REQ);
        slot_wr_o  = (state == ST_DIR_REQ);
        busy_o     = (state != ST_IDLE);
        done_o     = (state == ST_REPORT);
        publish_o  = (state_nx == ST_REPORT) && (state != ST_REPORT);
    end

    // R10: a request lasts one cycle only.
    a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_o |=> !slot_req_o);

    // R10: a stray slot completion while idle does not start anything.
    a_r10_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && slot_done_i && !start_i) |=> (state == ST_IDLE));

    // R7: done is a single-cycle pulse followed by idle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8: a busy sequencer never re-enters the first read request.
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_ID_REQ));

    // R8: the captured preferred direction holds while a step runs.
    a_r8_pref_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(pref_q_o));

endmodule

// File: rtl/rom_search_step.sv
// Top of the search triplet step engine.
// It joins the slot sequencer to the branch decision and holds the
// published status word.
// Assumes: slot generator handshake as described for srch_trip_seq.
module rom_search_step
    import srch_trip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pref_dir_i,
    output logic       slot_req_o,
    output logic       slot_wr_o,
    output logic       slot_val_o,
    input  logic       slot_done_i,
    input  logic       slot_bit_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] status_o
);

    logic         abort_w, dir_w, publish_w;
    logic         id_q, cmp_q, pref_q;
    step_result_t result_w, status_q;

    srch_trip_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pref_dir_i  (pref_dir_i),
        .slot_done_i (slot_done_i),
        .slot_bit_i  (slot_bit_i),
        .abort_i     (abort_w),
        .slot_req_o  (slot_req_o),
        .slot_wr_o   (slot_wr_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .publish_o   (publish_w),
        .id_q_o      (id_q),
        .cmp_q_o     (cmp_q),
        .pref_q_o    (pref_q)
    );

    srch_trip_branch u_branch (
        .id_bit_i   (id_q),
        .cmp_bit_i  (cmp_q),
        .pref_dir_i (pref_q),
        .abort_o    (abort_w),
        .dir_o      (dir_w),
        .result_o   (result_w)
    );

    // Hold the status word; replace it only when a step reports.
    always_ff @(posedge clk) begin
        if (!rst_n)         status_q <= '0;
        else if (publish_w) status_q <= result_w;
    end

    assign slot_val_o = dir_w;
    assign status_o   = status_q;

    // R4: no write slot is ever requested after two 1 reads.
    a_r4_no_write_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && slot_wr_o) |-> !(id_q && cmp_q));

    // R6: with disagreeing reads the written bit follows the identifier bit.
    a_r6_dir_follows_id: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && slot_wr_o && (id_q != cmp_q)) |-> (slot_val_o == id_q));

    // R9: the status word moves only in a done cycle.
    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(status_o));

endmodule

// File: tb/rom_search_step_tb_top.sv
`timescale 1ns/1ps
module rom_search_step_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pref_dir_i = 1'b0;
    logic       slot_done_i = 1'b0;
    logic       slot_bit_i = 1'b0;
    logic       slot_req_o, slot_wr_o, slot_val_o, busy_o, done_o;
    logic [2:0] status_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rom_search_step dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pref_dir_i  (pref_dir_i),
        .slot_req_o  (slot_req_o),
        .slot_wr_o   (slot_wr_o),
        .slot_val_o  (slot_val_o),
        .slot_done_i (slot_done_i),
        .slot_bit_i  (slot_bit_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .status_o    (status_o)
    );

    // Expected status from the requirements R4, R5 and R6.
    function automatic logic [2:0] exp_status(input logic id, input logic cmp, input logic pref);
        if (id && cmp) return 3'b011;
        if (id)        return 3'b101;
        if (cmp)       return 3'b010;
        return {pref, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Answer one outstanding slot after lat cycles, optionally poking start.
    task automatic serve(input int lat, input logic b, input bit poke, input logic pref);
        @(negedge clk);
        if (poke) begin
            start_i    = 1'b1;
            pref_dir_i = ~pref;
        end
        for (int i = 1; i < lat; i++) begin
            chk(!slot_req_o, "R10", {7'd0, slot_req_o}, 8'd0);
            @(negedge clk);
            start_i = 1'b0;
        end
        slot_done_i = 1'b1;
        slot_bit_i  = b;
        @(negedge clk);
        slot_done_i = 1'b0;
        start_i     = 1'b0;
        slot_bit_i  = 1'($urandom);
    endtask

    // One full step with the given read values and preferred direction.
    task automatic run_step(input logic id, input logic cmp, input logic pref, input bit poke);
        logic [2:0] e;
        logic [2:0] prev;
        string      tag;
        e    = exp_status(id, cmp, pref);
        prev = status_o;
        tag  = (id && cmp) ? "R4" : ((id ^ cmp) ? "R6" : (poke ? "R8" : "R5"));
        start_i    = 1'b1;
        pref_dir_i = pref;
        @(negedge clk);
        start_i    = 1'b0;
        pref_dir_i = 1'($urandom);
        chk(slot_req_o && !slot_wr_o && busy_o, "R2",
            {5'd0, slot_req_o, slot_wr_o, busy_o}, 8'b101);
        serve(1 + int'($urandom % 4), id, poke, pref);
        chk(slot_req_o && !slot_wr_o, "R3", {6'd0, slot_req_o, slot_wr_o}, 8'b10);
        chk(status_o == prev, "R9", {5'd0, status_o}, {5'd0, prev});
        serve(1 + int'($urandom % 4), cmp, 1'b0, pref);
        chk(!slot_req_o && !done_o, "R7", {6'd0, slot_req_o, done_o}, 8'd0);
        chk(status_o == prev, "R9", {5'd0, status_o}, {5'd0, prev});
        @(negedge clk);
        if (id && cmp) begin
            chk(done_o && !slot_req_o, "R4", {6'd0, done_o, slot_req_o}, 8'b10);
            chk(status_o == e, "R4", {5'd0, status_o}, {5'd0, e});
        end else begin
            chk(slot_req_o && slot_wr_o && slot_val_o == e[2], tag,
                {5'd0, slot_req_o, slot_wr_o, slot_val_o}, {5'd0, 2'b11, e[2]});
            serve(1 + int'($urandom % 4), 1'($urandom), 1'b0, pref);
            chk(done_o, "R7", {7'd0, done_o}, 8'd1);
            chk(status_o == e, tag, {5'd0, status_o}, {5'd0, e});
        end
        @(negedge clk);
        chk(!done_o && !busy_o, "R7", {6'd0, done_o, busy_o}, 8'd0);
        chk(status_o == e, "R9", {5'd0, status_o}, {5'd0, e});
    endtask

    initial begin
        void'($urandom(32'h1D5EED));
        repeat (3) @(negedge clk);
        chk(!busy_o && !slot_req_o && !done_o && status_o == 3'b000, "R1",
            {2'd0, busy_o, slot_req_o, done_o, status_o}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !slot_req_o && !done_o && status_o == 3'b000, "R1",
            {2'd0, busy_o, slot_req_o, done_o, status_o}, 8'd0);

        // Directed: every read combination with both preferred directions.
        for (int k = 0; k < 8; k++) run_step(k[0], k[1], k[2], 1'b0);

        // R8: start pokes with the opposite direction while busy.
        run_step(1'b0, 1'b0, 1'b1, 1'b1);
        run_step(1'b0, 1'b0, 1'b0, 1'b1);
        run_step(1'b1, 1'b0, 1'b0, 1'b1);

        // R10: stray slot completion while idle.
        begin
            logic [2:0] held;
            held        = status_o;
            slot_done_i = 1'b1;
            slot_bit_i  = 1'b1;
            @(negedge clk);
            slot_done_i = 1'b0;
            chk(!busy_o && !slot_req_o && !done_o, "R10",
                {5'd0, busy_o, slot_req_o, done_o}, 8'd0);
            @(negedge clk);
            chk(!busy_o && status_o == held, "R10", {4'd0, busy_o, status_o}, {5'd0, held});
        end

        // Random steps.
        for (int k = 0; k < 60; k++)
            run_step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule